// File: doc/BRIEF.md
# Control Register File with Write Validation

This block keeps the processor control registers numbered 0, 2, 3, 4 and 8 and carries out the move-to and move-from requests that target them. A request names a register through a 3-bit select field together with one extension bit, arrives with the two-bit addressing mode field of its instruction and the current privilege level, and either carries a 32-bit general-purpose value to write or asks for the stored value to be returned on a separate read bus.

Each write is checked before it is allowed to land. A write is refused if the requester is not at privilege level 0, if it asks for a forbidden combination of bits in register 0, or if it sets a reserved bit in register 4 or register 8. Reserved bits in registers 0 and 3 are dropped without a fault, and the extension-type bit of register 0 always reads as one. A write that is accepted can emit single-cycle strobes toward the translation buffers and the page-directory-pointer loader. The block only raises these strobes and does not perform the work they request.

All outputs change on the clock edge that follows the request cycle.

Top module: `ctrl_reg_file`

## Requirements
- R1: After reset, register 0 reads 0x0000_0010, with the extension-type bit 4 set. Registers 2, 3, 4 and 8 read zero, and every output strobe is low.
- R2: A request is undefined when the mode field is not 2'b11, or when the select does not resolve to a register. With the extension bit clear, selects 0, 2, 3 and 4 are valid; with the extension bit set, only select 0 is valid and it means register 8. An undefined request pulses `fault_ud` one cycle later, does not pulse `fault_gp` or `rd_valid`, raises no strobe and changes no register.
- R3: A valid request whose `cpl` is not 0 pulses `fault_gp` one cycle later. It returns no data, raises no strobe and changes no register.
- R4: A valid read at `cpl` 0 pulses `rd_valid` one cycle later, and `rd_data` then carries the stored value of the selected register. `rd_data` holds its value at all other times.
- R5: An accepted write to register 0 keeps only bits 0 to 5, 16, 18, 29, 30 and 31. All other bits are stored as zero, and bit 4 is stored as one whatever is written.
- R6: A write to register 0 faults with `fault_gp` and leaves the register unchanged when the written value has bit 31 set with bit 0 clear, or has bit 29 set with bit 30 clear.
- R7: An accepted write to register 3 keeps bits 3, 4 and 31 to 12, and stores every other bit as zero without faulting.
- R8: A write to register 4 that sets any bit from 11 upward faults, and so does a write to register 8 that sets any bit from 4 upward. Register 2 stores all 32 bits as written.
- R9: Every accepted write to register 3 pulses `tlb_flush_local` one cycle later.
- R10: `tlb_flush_all` pulses one cycle after an accepted write that changes one of these bits: bit 0 or bit 31 of register 0, or bit 4, 5 or 7 of register 4.
- R11: `ptr_reload` pulses one cycle after any of the following accepted writes. A write to register 4 that takes bit 5 from 0 to 1 while register 0 bit 31 is 1. A write to register 3 while register 4 bit 5 and register 0 bit 31 are both 1. A write to register 0 that takes bit 31 from 0 to 1 while register 4 bit 5 is 1.
- R12: A faulted write raises none of `tlb_flush_local`, `tlb_flush_all` or `ptr_reload`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to control register, 0 = move from it |
| mod_bits | input | 2 | Addressing mode field; must be 2'b11 |
| reg_idx | input | 3 | Control register select |
| reg_ext | input | 1 | Select extension bit (with select 0 means register 8) |
| cpl | input | 2 | Current privilege level |
| wr_data | input | 32 | General-purpose value to write |
| rd_valid | output | 1 | Read data returned |
| rd_data | output | 32 | Value read back |
| fault_ud | output | 1 | Undefined-request pulse |
| fault_gp | output | 1 | General-protection pulse |
| tlb_flush_local | output | 1 | Request to flush non-global translation entries |
| tlb_flush_all | output | 1 | Request to flush all translation entries, global ones included |
| ptr_reload | output | 1 | Request to reload the page-directory pointers |

## Verification
Two side effects can fire in the same cycle. A write to register 3 made while paging is on and register 4 bit 5 is set must raise both the local flush and the pointer reload. A write to register 4 that turns bit 5 on while paging is enabled must raise both the global flush and the reload. The bench sets up each state in turn by first writing registers 0 and 4, then makes the triggering write. A behavioural reference model, compared on every clock, predicts each strobe on its own, so a design that raises only one of the pair, or raises them a cycle apart, shows up as a mismatch. Faulted writes made in the same states check that the strobes stay silent when a write is refused.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int XLEN   = 32;
  localparam int NSLOT  = 5;

  typedef enum logic [2:0] {
    SEL_C0   = 3'd0,
    SEL_C2   = 3'd1,
    SEL_C3   = 3'd2,
    SEL_C4   = 3'd3,
    SEL_C8   = 3'd4,
    SEL_NONE = 3'd5
  } crsel_e;

  localparam int B_PE  = 0;
  localparam int B_ET  = 4;
  localparam int B_NW  = 29;
  localparam int B_CD  = 30;
  localparam int B_PG  = 31;
  localparam int B_PSE = 4;
  localparam int B_PAE = 5;
  localparam int B_PGE = 7;

  localparam logic [XLEN-1:0] C0_KEEP  = 32'hE005_003F;
  localparam logic [XLEN-1:0] C3_KEEP  = 32'hFFFF_F018;
  localparam logic [XLEN-1:0] C4_KEEP  = 32'h0000_07FF;
  localparam logic [XLEN-1:0] C8_KEEP  = 32'h0000_000F;
  localparam logic [XLEN-1:0] C0_RESET = 32'h0000_0010;
  localparam logic [XLEN-1:0] C4_PAGE_BITS =
    (32'h1 << B_PSE) | (32'h1 << B_PAE) | (32'h1 << B_PGE);

  function automatic logic [XLEN-1:0] c0_clean(input logic [XLEN-1:0] v);
    c0_clean = (v & C0_KEEP) | (32'h1 << B_ET);
  endfunction

  function automatic logic c0_combo_bad(input logic [XLEN-1:0] v);
    c0_combo_bad = (v[B_PG] & ~v[B_PE]) | (v[B_NW] & ~v[B_CD]);
  endfunction

  function automatic logic rsvd_hit(input logic [XLEN-1:0] v,
                                    input logic [XLEN-1:0] keep);
    rsvd_hit = |(v & ~keep);
  endfunction

  function automatic logic [XLEN-1:0] slot_reset(input int i);
    slot_reset = (i == 0) ? C0_RESET : '0;
  endfunction
endpackage

// File: rtl/crf_decode.sv
module crf_decode
  import crf_pkg::*;
(
  input  logic [1:0] mod_bits,
  input  logic [2:0] reg_idx,
  input  logic       reg_ext,
  output crsel_e     sel,
  output logic       sel_bad
);
  always_comb begin
    sel = SEL_NONE;
    if (mod_bits == 2'b11) begin
      if (reg_ext) begin
        if (reg_idx == 3'd0) sel = SEL_C8;
      end else begin
        case (reg_idx)
          3'd0:    sel = SEL_C0;
          3'd2:    sel = SEL_C2;
          3'd3:    sel = SEL_C3;
          3'd4:    sel = SEL_C4;
          default: sel = SEL_NONE;
        endcase
      end
    end
    sel_bad = (sel == SEL_NONE);
  end
endmodule

// File: rtl/crf_wcheck.sv
module crf_wcheck
  import crf_pkg::*;
(
  input  crsel_e          sel,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] cur_c0,
  input  logic [XLEN-1:0] cur_c4,
  output logic            val_fault,
  output logic [XLEN-1:0] clean_val,
  output logic            want_flush_local,
  output logic            want_flush_all,
  output logic            want_reload
);
  logic paging_on;
  logic pae_on;
  assign paging_on = cur_c0[B_PG];
  assign pae_on    = cur_c4[B_PAE];

  always_comb begin
    val_fault        = 1'b0;
    clean_val        = wdata;
    want_flush_local = 1'b0;
    want_flush_all   = 1'b0;
    want_reload      = 1'b0;
    case (sel)
      SEL_C0: begin
        clean_val      = c0_clean(wdata);
        val_fault      = c0_combo_bad(wdata);
        want_flush_all = (clean_val[B_PE] != cur_c0[B_PE]) ||
                         (clean_val[B_PG] != cur_c0[B_PG]);
        want_reload    = clean_val[B_PG] & ~paging_on & pae_on;
      end
      SEL_C3: begin
        clean_val        = wdata & C3_KEEP;
        want_flush_local = 1'b1;
        want_reload      = pae_on & paging_on;
      end
      SEL_C4: begin
        val_fault      = rsvd_hit(wdata, C4_KEEP);
        want_flush_all = |((wdata ^ cur_c4) & C4_PAGE_BITS);
        want_reload    = wdata[B_PAE] & ~pae_on & paging_on;
      end
      SEL_C8: begin
        val_fault = rsvd_hit(wdata, C8_KEEP);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/crf_store.sv
module crf_store
  import crf_pkg::*;
#(
  parameter int SLOTS = NSLOT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  crsel_e          sel,
  input  logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] slot_q [SLOTS]
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[i] <= slot_reset(i);
      else if (we && (int'(sel) == i))
        slot_q[i] <= wval;
    end
  end
endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
  import crf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      mod_bits,
  input  logic [2:0]      reg_idx,
  input  logic            reg_ext,
  input  logic [1:0]      cpl,
  input  logic [XLEN-1:0] wr_data,
  output logic            rd_valid,
  output logic [XLEN-1:0] rd_data,
  output logic            fault_ud,
  output logic            fault_gp,
  output logic            tlb_flush_local,
  output logic            tlb_flush_all,
  output logic            ptr_reload
);
  crsel_e          sel;
  logic            sel_bad;
  logic            val_fault;
  logic [XLEN-1:0] clean_val;
  logic            want_flush_local, want_flush_all, want_reload;
  logic [XLEN-1:0] slot_q [NSLOT];
  logic [XLEN-1:0] cr0_now, cr3_now, cr4_now;
  logic [XLEN-1:0] rd_value;

  // named internal events
  logic priv_bad, evt_ud, evt_gp, evt_wr, evt_rd;

  crf_decode u_dec (
    .mod_bits (mod_bits),
    .reg_idx  (reg_idx),
    .reg_ext  (reg_ext),
    .sel      (sel),
    .sel_bad  (sel_bad)
  );

  assign cr0_now = slot_q[0];
  assign cr3_now = slot_q[2];
  assign cr4_now = slot_q[3];

  crf_wcheck u_chkw (
    .sel              (sel),
    .wdata            (wr_data),
    .cur_c0           (cr0_now),
    .cur_c4           (cr4_now),
    .val_fault        (val_fault),
    .clean_val        (clean_val),
    .want_flush_local (want_flush_local),
    .want_flush_all   (want_flush_all),
    .want_reload      (want_reload)
  );

  assign priv_bad = (cpl != 2'd0);
  assign evt_ud   = req_valid & sel_bad;
  assign evt_gp   = req_valid & ~sel_bad & (priv_bad | (req_write & val_fault));
  assign evt_wr   = req_valid & req_write & ~sel_bad & ~priv_bad & ~val_fault;
  assign evt_rd   = req_valid & ~req_write & ~sel_bad & ~priv_bad;

  crf_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (evt_wr),
    .sel    (sel),
    .wval   (clean_val),
    .slot_q (slot_q)
  );

  always_comb begin
    rd_value = '0;
    if (!sel_bad) rd_value = slot_q[int'(sel)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid        <= 1'b0;
      rd_data         <= '0;
      fault_ud        <= 1'b0;
      fault_gp        <= 1'b0;
      tlb_flush_local <= 1'b0;
      tlb_flush_all   <= 1'b0;
      ptr_reload      <= 1'b0;
    end else begin
      rd_valid        <= evt_rd;
      if (evt_rd) rd_data <= rd_value;
      fault_ud        <= evt_ud;
      fault_gp        <= evt_gp;
      tlb_flush_local <= evt_wr & want_flush_local;
      tlb_flush_all   <= evt_wr & want_flush_all;
      ptr_reload      <= evt_wr & want_reload;
    end
  end
endmodule

// File: rtl/ctrl_reg_file_chk.sv
module ctrl_reg_file_chk
  import crf_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [1:0]      mod_bits,
  input logic [2:0]      reg_idx,
  input logic            reg_ext,
  input logic [1:0]      cpl,
  input logic            rd_valid,
  input logic            fault_ud,
  input logic            fault_gp,
  input logic            tlb_flush_local,
  input logic            tlb_flush_all,
  input logic            ptr_reload,
  input logic [XLEN-1:0] cr0_now,
  input logic [XLEN-1:0] cr3_now
);
  // R1
  et_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_now[B_ET] == 1'b1);

  // R7
  cr3_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cr3_now & ~C3_KEEP) == '0);

  // R2
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mod_bits != 2'b11) |=> (fault_ud && !fault_gp && !rd_valid));

  // R3
  priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mod_bits == 2'b11 && !reg_ext && reg_idx == 3'd2 && cpl != 2'd0)
      |=> (fault_gp && !rd_valid));

  // R3
  priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cpl != 2'd0) |=> ($stable(cr0_now) && $stable(cr3_now)));

  // R4
  read_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));

  // R9
  local_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_local |-> $past(req_valid && req_write && !reg_ext &&
                              reg_idx == 3'd3 && cpl == 2'd0 && mod_bits == 2'b11));

  // R12
  strobe_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_flush_local || tlb_flush_all || ptr_reload) |-> (!fault_gp && !fault_ud));

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_ud, fault_gp, rd_valid}));
endmodule

bind ctrl_reg_file ctrl_reg_file_chk u_crf_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_write       (req_write),
  .mod_bits        (mod_bits),
  .reg_idx         (reg_idx),
  .reg_ext         (reg_ext),
  .cpl             (cpl),
  .rd_valid        (rd_valid),
  .fault_ud        (fault_ud),
  .fault_gp        (fault_gp),
  .tlb_flush_local (tlb_flush_local),
  .tlb_flush_all   (tlb_flush_all),
  .ptr_reload      (ptr_reload),
  .cr0_now         (cr0_now),
  .cr3_now         (cr3_now)
);

// File: tb/ctrl_reg_file_test.sv
module ctrl_reg_file_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  mod_bits = 2'b11;
  logic [2:0]  reg_idx = 3'd0;
  logic        reg_ext = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic [31:0] wr_data = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        fault_ud, fault_gp, tlb_flush_local, tlb_flush_all, ptr_reload;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state, indexed by architectural register number
  logic [31:0] mr [0:8];
  logic [31:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_reg_file uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .mod_bits(mod_bits), .reg_idx(reg_idx), .reg_ext(reg_ext), .cpl(cpl),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .fault_ud(fault_ud), .fault_gp(fault_gp), .tlb_flush_local(tlb_flush_local),
    .tlb_flush_all(tlb_flush_all), .ptr_reload(ptr_reload)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ok0();
    return 32'h0000_003F | (32'h1 << 16) | (32'h1 << 18) | (32'h7 << 29);
  endfunction

  // one request per clock; model predicts, then compare after the edge
  task automatic step(input string tag, input bit v, input bit wr,
                      input logic [1:0] md, input int r, input bit ext,
                      input int lvl, input logic [31:0] d);
    int idx;
    bit e_ud, e_gp, e_rv, e_fl, e_fa, e_pr;
    logic [31:0] nv;
    e_ud = 0; e_gp = 0; e_rv = 0; e_fl = 0; e_fa = 0; e_pr = 0;
    idx = -1;
    if (md == 2'b11) begin
      if (ext) begin
        if (r == 0) idx = 8;
      end else if (r == 0 || r == 2 || r == 3 || r == 4) idx = r;
    end
    req_valid = v; req_write = wr; mod_bits = md; reg_idx = r[2:0];
    reg_ext = ext; cpl = lvl[1:0]; wr_data = d;
    if (v) begin
      if (idx < 0) e_ud = 1;
      else if (lvl != 0) e_gp = 1;
      else if (!wr) begin
        e_rv = 1; last_rd = mr[idx];
      end else begin
        case (idx)
          0: begin
            if ((d[31] && !d[0]) || (d[29] && !d[30])) e_gp = 1;
            else begin
              nv = (d & ok0()) | 32'h10;
              e_fa = (nv[0] != mr[0][0]) || (nv[31] != mr[0][31]);
              e_pr = nv[31] && !mr[0][31] && mr[4][5];
              mr[0] = nv;
            end
          end
          2: mr[2] = d;
          3: begin
            e_fl = 1;
            e_pr = mr[4][5] && mr[0][31];
            mr[3] = {d[31:12], 7'd0, d[4:3], 3'd0};
          end
          4: begin
            if ((d >> 11) != 0) e_gp = 1;
            else begin
              e_fa = (d[4] != mr[4][4]) || (d[5] != mr[4][5]) || (d[7] != mr[4][7]);
              e_pr = d[5] && !mr[4][5] && mr[0][31];
              mr[4] = d;
            end
          end
          default: begin
            if ((d >> 4) != 0) e_gp = 1;
            else mr[8] = d;
          end
        endcase
      end
    end
    @(negedge clk);
    chk(tag, "fault_ud",        fault_ud,        e_ud);
    chk(tag, "fault_gp",        fault_gp,        e_gp);
    chk(tag, "rd_valid",        rd_valid,        e_rv);
    chk(tag, "rd_data",         rd_data,         last_rd);
    chk(tag, "tlb_flush_local", tlb_flush_local, e_fl);
    chk(tag, "tlb_flush_all",   tlb_flush_all,   e_fa);
    chk(tag, "ptr_reload",      ptr_reload,      e_pr);
    req_valid = 1'b0;
  endtask

  task automatic rd(input string tag, input int r, input bit ext);
    step(tag, 1, 0, 2'b11, r, ext, 0, 32'h0);
  endtask

  task automatic wrq(input string tag, input int r, input bit ext, input logic [31:0] d);
    step(tag, 1, 1, 2'b11, r, ext, 0, d);
  endtask

  initial begin
    for (int i = 0; i <= 8; i++) mr[i] = '0;
    mr[0] = 32'h10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    step("R1", 0, 0, 2'b11, 0, 0, 0, 0);
    rd("R1", 0, 0); rd("R1", 2, 0); rd("R1", 3, 0); rd("R1", 4, 0); rd("R1", 0, 1);
    // R2: undefined encodings
    step("R2", 1, 1, 2'b10, 2, 0, 0, 32'hFFFF_FFFF);
    step("R2", 1, 0, 2'b00, 0, 0, 0, 0);
    wrq("R2", 1, 0, 32'h1234);
    wrq("R2", 3, 1, 32'h1);
    rd("R2", 5, 0);
    rd("R2", 2, 0);
    // R3: privilege
    step("R3", 1, 1, 2'b11, 2, 0, 3, 32'hCAFE_F00D);
    step("R3", 1, 0, 2'b11, 0, 0, 1, 0);
    rd("R3", 2, 0);
    // R4 / R8: register 2 full width
    wrq("R8", 2, 0, 32'hDEAD_BEEF);
    rd("R4", 2, 0);
    // R5 / R10: register 0 masking and paging change
    wrq("R5", 0, 0, 32'hFFFF_FFFF);
    rd("R5", 0, 0);
    // R6: illegal combos
    wrq("R6", 0, 0, 32'h8000_0000);
    wrq("R6", 0, 0, 32'h2000_0001);
    rd("R6", 0, 0);
    wrq("R5", 0, 0, 32'h0000_0000);
    rd("R5", 0, 0);
    // R7 / R9: register 3
    wrq("R7", 3, 0, 32'hFFFF_FFFF);
    rd("R7", 3, 0);
    // R8: reserved faults
    wrq("R8", 4, 0, 32'h0000_0800);
    wrq("R8", 0, 1, 32'h0000_0010);
    wrq("R8", 0, 1, 32'h0000_0005);
    rd("R8", 0, 1);
    rd("R8", 4, 0);
    // R10: register 4 paging bits
    wrq("R10", 4, 0, 32'h0000_0020);
    wrq("R10", 4, 0, 32'h0000_0021);
    wrq("R10", 4, 0, 32'h0000_00A1);
    // R11: register 0 turns paging on with PAE set
    wrq("R11", 0, 0, 32'h8000_0001);
    // R9 + R11 same cycle
    wrq("R9", 3, 0, 32'h1234_5018);
    rd("R9", 3, 0);
    // R11 + R10 same cycle: PAE 0->1 with paging on
    wrq("R10", 4, 0, 32'h0000_0000);
    wrq("R11", 4, 0, 32'h0000_0020);
    // R12: refused writes in a state that would strobe
    step("R12", 1, 1, 2'b11, 3, 0, 1, 32'h0000_1000);
    wrq("R12", 4, 0, 32'h0001_0000);
    wrq("R12", 0, 0, 32'h2000_0001);
    rd("R12", 3, 0);
    rd("R12", 0, 0);
    step("R12", 0, 0, 2'b11, 0, 0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule